// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block decides, every cycle, how the operand-fetch stage of a scalar in-order five-stage pipeline (fetch, decode, operand fetch, execute, write back) obtains its two source operands, and whether the pipeline must pause. It compares the two source register numbers of the instruction in operand fetch with the destination numbers of the instructions now in execute and write back. Each operand then comes from the register file, from the execute-stage result bypass, or from the write-back bypass. The write-back bypass carries the data that a load brings back from the data cache.

When no bypass can supply a value in time, the controller interlocks. This happens when a load in execute produces a value that the next instruction needs. It also happens when the single shared register-file port is taken by a write-back write while operand fetch still needs to read the file. In both cases fetch, decode and operand fetch hold, and a no-operation enters execute. A busy multi-cycle divider holds the front stages and execute as well. No bubble enters in that case, so the divide is kept.

Top module: `hazard_ctrl`

## Requirements
- R1: With no producer matching either source, both operand selects read 0 (register file) and stall_front, stall_exec and bubble_ex are all 0.
- R2: A valid, register-writing instruction of class ALU (code 0), or of class divide (code 2) with div_busy low, in execute whose destination equals a nonzero source selects code 1 (execute result bypass) for that source, without stalling.
- R3: A valid, register-writing instruction in write back whose destination equals a nonzero source selects code 2 (write-back/load-data bypass) for that source, when execute does not match that source.
- R4: When execute and write back both match a source, the execute-stage (younger) producer wins and the select is 1.
- R5: A load (class code 1) in execute matching a nonzero source of a valid operand-fetch instruction gives stall_front=1, bubble_ex=1 and stall_exec=0.
- R6: Register 0, an invalid operand-fetch slot, an invalid producer slot, or a producer that does not write never creates a dependency, so the select stays 0 and no data stall arises.
- R7: With the shared port option on (default), rf_wr_act=1 together with a valid operand-fetch instruction that reads a nonzero source from the register file (select 0) gives stall_front=1 and bubble_ex=1. No stall arises when every nonzero source is bypassed, or when the slot is invalid.
- R8: div_busy=1 gives stall_front=1 and stall_exec=1 with bubble_ex=0, whatever data or port conflict also exists.
- R9: The two sources are resolved independently; each select reflects only its own source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the built-in checks |
| rst_n | input | 1 | Active-low reset, disables checks |
| of_valid | input | 1 | Operand-fetch slot holds a real instruction |
| of_rs1 | input | REG_AW | First source register of operand-fetch instruction |
| of_rs2 | input | REG_AW | Second source register of operand-fetch instruction |
| ex_valid | input | 1 | Execute slot holds a real instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_rd | input | REG_AW | Execute destination register |
| ex_cls | input | 2 | Execute class: 0 ALU, 1 load, 2 divide |
| wb_valid | input | 1 | Write-back slot holds a real instruction |
| wb_wr | input | 1 | Write-back instruction writes a register |
| wb_rd | input | REG_AW | Write-back destination register |
| rf_wr_act | input | 1 | Register-file port is used for a write this cycle |
| div_busy | input | 1 | Multi-cycle divider occupied |
| sel_a | output | 2 | Source for operand 1: 0 file, 1 execute bypass, 2 write-back bypass |
| sel_b | output | 2 | Source for operand 2, same encoding |
| stall_front | output | 1 | Hold fetch, decode and operand-fetch registers |
| stall_exec | output | 1 | Hold the execute stage |
| bubble_ex | output | 1 | Inject a no-operation into execute |

## Verification
The bench drives producer patterns that pull the two selects apart: a match only in execute, only in write back, in both at once, and with a different producer on each source. These show whether bypass choice and youngest-first priority work per source. Patterns with register 0, cleared valid bits or a non-writing producer tell a real dependency from a false one. Load-use, port-conflict and divider-busy cases, each with and without a competing condition, show which stall form is chosen and that a divider hold never drops the divide with a bubble.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int MAX_AW = 8;
  typedef logic [MAX_AW-1:0] regid_t;

  typedef enum logic [1:0] {CLS_ALU = 2'd0, CLS_LOAD = 2'd1, CLS_DIV = 2'd2} icls_e;
  typedef enum logic [1:0] {OPND_RF = 2'd0, OPND_ALU = 2'd1, OPND_WB = 2'd2} opsel_e;

  // a producer slot feeds a source when it is live, writes, and names that source
  function automatic logic producer_hit(input logic live, input logic writes,
                                        input regid_t dst, input regid_t src);
    return live && writes && (src != '0) && (dst == src);
  endfunction

  // result of an execute-stage producer is ready for bypass unless it is a load
  // still in the cache, or a divide whose unit is still working
  function automatic logic ex_result_ready(input logic [1:0] cls, input logic busy);
    return (cls == CLS_ALU) || ((cls == CLS_DIV) && !busy);
  endfunction
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              use_valid,
  input  logic [REG_AW-1:0] src,
  input  logic              ex_valid,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic [1:0]        ex_cls,
  input  logic              wb_valid,
  input  logic              wb_wr,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              div_busy,
  output opsel_e            sel,
  output logic              load_wait,
  output logic              rf_read
);
  logic ex_hit, wb_hit;

  assign ex_hit = use_valid && producer_hit(ex_valid, ex_wr, regid_t'(ex_rd), regid_t'(src));
  assign wb_hit = use_valid && producer_hit(wb_valid, wb_wr, regid_t'(wb_rd), regid_t'(src));

  always_comb begin
    sel       = OPND_RF;
    load_wait = 1'b0;
    if (ex_hit) begin
      if (ex_result_ready(ex_cls, div_busy)) sel = OPND_ALU;
      else if (ex_cls == CLS_LOAD)           load_wait = 1'b1;
      else                                   sel = OPND_ALU;
    end else if (wb_hit) begin
      sel = OPND_WB;
    end
  end

  assign rf_read = use_valid && (src != '0) && (sel == OPND_RF) && !load_wait;
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl #(
  parameter int NUM_SRC        = 2,
  parameter bit SHARED_RF_PORT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] load_wait,
  input  logic [NUM_SRC-1:0] rf_read,
  input  logic               rf_wr_act,
  input  logic               div_busy,
  output logic               stall_front,
  output logic               stall_exec,
  output logic               bubble_ex
);
  logic data_stall, port_stall;

  assign data_stall = |load_wait;

  generate
    if (SHARED_RF_PORT) begin : g_shared
      assign port_stall = rf_wr_act && (|rf_read);
    end else begin : g_split
      assign port_stall = 1'b0;
    end
  endgenerate

  always_comb begin
    stall_front = 1'b0;
    stall_exec  = 1'b0;
    bubble_ex   = 1'b0;
    if (div_busy) begin
      stall_front = 1'b1;
      stall_exec  = 1'b1;
    end else if (data_stall || port_stall) begin
      stall_front = 1'b1;
      bubble_ex   = 1'b1;
    end
  end

  // R8
  div_no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_exec |-> (stall_front && !bubble_ex));

  // R5
  bubble_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |-> (stall_front && !stall_exec));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_AW         = 5,
  parameter bit SHARED_RF_PORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              of_valid,
  input  logic [REG_AW-1:0] of_rs1,
  input  logic [REG_AW-1:0] of_rs2,
  input  logic              ex_valid,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic [1:0]        ex_cls,
  input  logic              wb_valid,
  input  logic              wb_wr,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              rf_wr_act,
  input  logic              div_busy,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              stall_front,
  output logic              stall_exec,
  output logic              bubble_ex
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_AW-1:0] src_id;
  opsel_e                         src_sel [NUM_SRC];
  logic [NUM_SRC-1:0]             load_wait;
  logic [NUM_SRC-1:0]             rf_read;

  assign src_id[0] = of_rs1;
  assign src_id[1] = of_rs2;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      hz_src_match #(.REG_AW(REG_AW)) u_match (
        .use_valid (of_valid),
        .src       (src_id[g]),
        .ex_valid  (ex_valid),
        .ex_wr     (ex_wr),
        .ex_rd     (ex_rd),
        .ex_cls    (ex_cls),
        .wb_valid  (wb_valid),
        .wb_wr     (wb_wr),
        .wb_rd     (wb_rd),
        .div_busy  (div_busy),
        .sel       (src_sel[g]),
        .load_wait (load_wait[g]),
        .rf_read   (rf_read[g])
      );
    end
  endgenerate

  assign sel_a = src_sel[0];
  assign sel_b = src_sel[1];

  hz_stall_ctrl #(.NUM_SRC(NUM_SRC), .SHARED_RF_PORT(SHARED_RF_PORT)) u_stall (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_wait   (load_wait),
    .rf_read     (rf_read),
    .rf_wr_act   (rf_wr_act),
    .div_busy    (div_busy),
    .stall_front (stall_front),
    .stall_exec  (stall_exec),
    .bubble_ex   (bubble_ex)
  );

  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (of_rs1 == '0) |-> (sel_a == OPND_RF));

  // R4
  ex_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == OPND_ALU) |-> (of_valid && ex_valid && ex_wr && (ex_rd == of_rs1)));

  // R3
  wb_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == OPND_WB) |-> (wb_valid && wb_wr && (wb_rd == of_rs2) &&
                            !(ex_valid && ex_wr && (ex_rd == of_rs2))));

  // R5
  load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (of_valid && ex_valid && ex_wr && (ex_cls == CLS_LOAD) && !div_busy &&
     (ex_rd != '0) && ((ex_rd == of_rs1) || (ex_rd == of_rs2)))
    |-> (bubble_ex && stall_front));

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (stall_front && stall_exec && !bubble_ex));
endmodule

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       of_valid = 0, ex_valid = 0, ex_wr = 0, wb_valid = 0, wb_wr = 0;
  logic       rf_wr_act = 0, div_busy = 0;
  logic [4:0] of_rs1 = 0, of_rs2 = 0, ex_rd = 0, wb_rd = 0;
  logic [1:0] ex_cls = 0;
  logic [1:0] sel_a, sel_b;
  logic       stall_front, stall_exec, bubble_ex;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       sf;
    logic       se;
    logic       bu;
    string      tag;
  } exp_t;

  exp_t scb[$];
  int   compared = 0;
  int   mismatched = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  hazard_ctrl i_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .of_valid(of_valid), .of_rs1(of_rs1), .of_rs2(of_rs2),
    .ex_valid(ex_valid), .ex_wr(ex_wr), .ex_rd(ex_rd), .ex_cls(ex_cls),
    .wb_valid(wb_valid), .wb_wr(wb_wr), .wb_rd(wb_rd), .rf_wr_act(rf_wr_act),
    .div_busy(div_busy), .sel_a(sel_a), .sel_b(sel_b), .stall_front(stall_front),
    .stall_exec(stall_exec), .bubble_ex(bubble_ex)
  );

  // class codes: 0 ALU, 1 load, 2 divide; select codes: 0 file, 1 execute, 2 write back
  task automatic drive(input logic ov, input logic [4:0] s1, input logic [4:0] s2,
                       input logic ev, input logic ew, input logic [4:0] erd, input logic [1:0] ec,
                       input logic wv, input logic ww, input logic [4:0] wrd,
                       input logic ract, input logic db,
                       input logic [1:0] xa, input logic [1:0] xb,
                       input logic xsf, input logic xse, input logic xbu, input string tag);
    exp_t e;
    @(negedge clk);
    of_valid = ov; of_rs1 = s1; of_rs2 = s2;
    ex_valid = ev; ex_wr = ew; ex_rd = erd; ex_cls = ec;
    wb_valid = wv; wb_wr = ww; wb_rd = wrd;
    rf_wr_act = ract; div_busy = db;
    e.a = xa; e.b = xb; e.sf = xsf; e.se = xse; e.bu = xbu; e.tag = tag;
    scb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (scb.size() > 0) begin
        exp_t e;
        e = scb.pop_front();
        compared++;
        if (sel_a !== e.a || sel_b !== e.b || stall_front !== e.sf ||
            stall_exec !== e.se || bubble_ex !== e.bu) begin
          mismatched++;
          $display("FAIL %s: got sel_a=%0d sel_b=%0d sf=%0b se=%0b bu=%0b, expected sel_a=%0d sel_b=%0d sf=%0b se=%0b bu=%0b",
                   e.tag, sel_a, sel_b, stall_front, stall_exec, bubble_ex,
                   e.a, e.b, e.sf, e.se, e.bu);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stimulus
    // R1 reset state with idle inputs
    @(negedge clk);
    if (sel_a !== 2'd0 || sel_b !== 2'd0 || stall_front !== 1'b0 || bubble_ex !== 1'b0 || stall_exec !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset: got %0d %0d %0b %0b %0b, expected 0 0 0 0 0",
               sel_a, sel_b, stall_front, stall_exec, bubble_ex);
    end
    compared++;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    //     ov s1 s2 ev ew erd ec wv ww wrd ract db  a  b  sf se bu
    drive(1, 3, 4, 1, 1, 7, 0, 1, 1, 9, 0, 0,  0, 0, 0, 0, 0, "R1 no match");
    drive(1, 5, 4, 1, 1, 5, 0, 0, 0, 0, 0, 0,  1, 0, 0, 0, 0, "R2 ALU bypass rs1");
    drive(1, 3, 4, 1, 1, 9, 0, 1, 1, 4, 0, 0,  0, 2, 0, 0, 0, "R3 wb bypass rs2");
    drive(1, 6, 6, 1, 1, 6, 0, 1, 1, 6, 0, 0,  1, 1, 0, 0, 0, "R4 youngest wins");
    drive(1, 7, 8, 1, 1, 7, 0, 1, 1, 8, 0, 0,  1, 2, 0, 0, 0, "R9 independent sources");
    drive(1, 2, 11, 1, 1, 11, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R5 load use rs2");
    drive(1, 12, 12, 1, 1, 12, 1, 1, 1, 12, 0, 0, 0, 0, 1, 0, 1, "R5 load use both, wb also");
    drive(1, 3, 0, 1, 1, 8, 1, 1, 1, 3, 0, 0,  2, 0, 0, 0, 0, "R3 load data from wb");
    drive(1, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0, 0,  0, 0, 0, 0, 0, "R6 register zero");
    drive(1, 5, 5, 0, 1, 5, 1, 0, 1, 5, 0, 0,  0, 0, 0, 0, 0, "R6 invalid producers");
    drive(1, 5, 5, 1, 0, 5, 1, 1, 0, 5, 0, 0,  0, 0, 0, 0, 0, "R6 non-writing producers");
    drive(0, 5, 5, 1, 1, 5, 1, 1, 1, 5, 1, 0,  0, 0, 0, 0, 0, "R6 invalid consumer");
    drive(1, 3, 0, 1, 1, 9, 0, 1, 1, 10, 1, 0, 0, 0, 1, 0, 1, "R7 port conflict");
    drive(1, 3, 4, 1, 1, 3, 0, 1, 1, 4, 1, 0,  1, 2, 0, 0, 0, "R7 all bypassed no conflict");
    drive(1, 0, 0, 1, 1, 3, 0, 1, 1, 4, 1, 0,  0, 0, 0, 0, 0, "R7 no file read");
    drive(1, 5, 2, 1, 1, 5, 2, 0, 0, 0, 0, 1,  1, 0, 1, 1, 0, "R8 divider busy");
    drive(1, 5, 2, 1, 1, 5, 2, 0, 0, 0, 0, 0,  1, 0, 0, 0, 0, "R2 divide done bypass");
    drive(1, 3, 0, 1, 1, 9, 2, 0, 0, 0, 1, 1,  0, 0, 1, 1, 0, "R8 busy over port conflict");
    drive(1, 3, 4, 1, 1, 7, 0, 1, 1, 9, 0, 0,  0, 0, 0, 0, 0, "R1 return to idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule